// File: doc/BRIEF.md
# Limit-Compare Interval Timer

This block is a register-mapped interval timer with one level interrupt. A prescaler turns the system clock into a fixed time-base tick. On every tick a 22-bit counter advances by one. The counter sits in bits 30..9 of a 32-bit count word, so the count word steps by 0x200 per tick and its low nine bits always read as zero. When the counter equals the programmed limit on a tick, it wraps to zero on that same tick and a sticky flag in bit 31 of the count word is set. Outside user mode the interrupt is raised at the same moment. This makes the interrupt periodic with a period of limit+1 ticks.

Software reaches the block through a simple strobe interface: a 3-bit word index covers a 32-byte window. Software can load the limit either with a restart of the count or without one. It acknowledges the interrupt by reading the limit word.

The block has three modes: processor, user and system. A mode write can switch only between processor and user mode; a timer in system mode stays there. User mode turns the block into a free-running counter over its full range that never interrupts.

Top module: `interval_timer`

## Requirements
- R1: After reset, irq is 0, the count word reads 0, the mode word reads the INIT_MODE code, and the counter does not advance until software writes word 0, writes word 2 or enters user mode.
- R2: While running, the counter advances once every TICK_DIV clock cycles. Reading word 1 returns {reached, counter[21:0], 9'b0}.
- R3: On a tick where the counter equals the limit, the counter becomes 0 and bit 31 of word 1 is set. In processor or system mode, irq is also set to 1.
- R4: Reading word 0 returns {1'b0, limit[21:0], 9'b0}. Outside user mode, this read clears the reached flag and irq. If a limit event happens in the same cycle, the event wins.
- R5: Writing word 0 takes the limit from wdata[30:9], sets the counter and the prescaler to 0, drives irq to 0 and starts the counter.
- R6: Writing word 2 takes the limit from wdata[30:9] and leaves the counter and the prescaler untouched. It starts the counter if it is stopped. Reading word 2 returns the same value as word 0 but acknowledges nothing.
- R7: A write to word 3 sets the mode from wdata[0] (1 = user, 0 = processor), but only while the mode is processor or user. Reading word 3 returns the mode code in bits 1..0: 0 = processor, 1 = user, 2 = system.
- R8: A mode write that selects user mode drives irq to 0, forces the limit to all ones and starts the counter. While in user mode, irq stays 0 and writes to word 0 or word 2 leave the limit unchanged.
- R9: Words 4 to 7 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 3 | Word index into the 32-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after rd_en |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a word 2 limit load on a live counter, followed by an acknowledge read that lands on the very tick of a limit event. Both depend on where the prescaler and the counter are at that instant. The random phase mixes restarts, in-place limit loads, acknowledge reads and mode flips with random gaps. It keeps word 2 limits at or above the current one so that events keep happening. A reference model, updated each clock, judges every read and checks irq on every cycle. A second instance built for system mode shows that its mode is locked while its interrupt still works.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int FRAC_W = 9;
  localparam int CNT_W  = DATA_W - 1 - FRAC_W;

  typedef enum logic [1:0] {
    MODE_PROC = 2'd0,
    MODE_USER = 2'd1,
    MODE_SYS  = 2'd2
  } tmr_mode_e;

  localparam logic [ADDR_W-1:0] A_LIM_RST = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LIM_RUN = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODE    = 3'd3;
endpackage

// File: rtl/timer_tick.sv
module timer_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) pre <= '0;
    else if (pre == LAST)     pre <= '0;
    else                      pre <= pre + 1'b1;
  end

  assign tick = run && (pre == LAST);

  // R1: a stopped timer leaves the phase at zero
  assert_idle_phase_R1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pre == '0));
endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int CW = timer_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          restart,
  input  logic          load_lim,
  input  logic [CW-1:0] lim_in,
  input  logic          force_full,
  input  logic          ack,
  input  logic          irq_en,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] lim,
  output logic          reached,
  output logic          irq
);
  logic hit, evt, set_irq;

  assign hit     = (cnt == lim);
  assign evt     = tick && hit && !restart;
  assign set_irq = evt && irq_en && !force_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      lim     <= '0;
      reached <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (force_full)    lim <= '1;
      else if (load_lim) lim <= lim_in;

      if (restart)   cnt <= '0;
      else if (tick) cnt <= hit ? '0 : cnt + 1'b1;

      if (evt)      reached <= 1'b1;
      else if (ack) reached <= 1'b0;

      if (restart || force_full) irq <= 1'b0;
      else if (set_irq)          irq <= 1'b1;
      else if (ack)              irq <= 1'b0;
    end
  end

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    evt |=> (cnt == '0) && reached);

  assert_irq_flag_R3: assert property (@(posedge clk) disable iff (rst)
    irq |-> reached);

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (ack && !evt) |=> (!reached && !irq));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int        TICK_DIV  = 50,
  parameter tmr_mode_e INIT_MODE = MODE_PROC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  tmr_mode_e  mode;
  logic       run;
  logic       tick, user, wr_rst, wr_run, wr_mode, enter_user, ack;
  logic [CNT_W-1:0] cnt, lim;
  logic       reached;

  assign user       = (mode == MODE_USER);
  assign wr_rst     = wr_en && (addr == A_LIM_RST);
  assign wr_run     = wr_en && (addr == A_LIM_RUN);
  assign wr_mode    = wr_en && (addr == A_MODE) && (mode != MODE_SYS);
  assign enter_user = wr_mode && wdata[0];
  assign ack        = rd_en && (addr == A_LIM_RST) && !user;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= INIT_MODE;
      run  <= 1'b0;
    end else begin
      if (wr_mode) mode <= wdata[0] ? MODE_USER : MODE_PROC;
      if (wr_rst || wr_run || enter_user) run <= 1'b1;
    end
  end

  timer_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .clear(wr_rst),
    .tick (tick)
  );

  timer_core #(.CW(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .restart   (wr_rst),
    .load_lim  ((wr_rst || wr_run) && !user),
    .lim_in    (wdata[DATA_W-2:FRAC_W]),
    .force_full(enter_user),
    .ack       (ack),
    .irq_en    (!user),
    .cnt       (cnt),
    .lim       (lim),
    .reached   (reached),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_LIM_RST, A_LIM_RUN: rdata <= {1'b0, lim, {FRAC_W{1'b0}}};
        A_COUNT:              rdata <= {reached, cnt, {FRAC_W{1'b0}}};
        A_MODE:               rdata <= {{(DATA_W-2){1'b0}}, mode};
        default:              rdata <= '0;
      endcase
    end
  end

  assert_user_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    user |-> !irq);

  assert_sys_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SYS) |=> (mode == MODE_SYS));

  assert_stopped_R1: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> $stable(cnt));

  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    wr_rst |=> ((cnt == '0) && !irq));
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  import timer_pkg::*;
  localparam int DIV = 4;
  localparam logic [21:0] FULL = '1;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  logic s_wr = 0, s_rd = 0;
  logic [2:0] s_addr = 0;
  logic [31:0] s_wdata = 0, s_rdata;
  logic s_irq;

  int checks = 0, failures = 0;
  bit done = 0, irq_watch = 0;

  always #5 clk = ~clk;

  interval_timer #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  interval_timer #(.TICK_DIV(DIV), .INIT_MODE(MODE_SYS)) dut_sys (
    .clk(clk), .rst(rst), .wr_en(s_wr), .rd_en(s_rd), .addr(s_addr),
    .wdata(s_wdata), .rdata(s_rdata), .irq(s_irq));

  // reference model, state updated at each rising edge
  bit m_run, m_reached, m_irq;
  int m_pre;
  logic [21:0] m_cnt, m_lim;
  logic [1:0] m_mode;
  logic [31:0] m_rexp;
  bit tk, hit, wr0, wr2, wrm, rd0, usr, evt, entu;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_pre = 0; m_cnt = 0; m_lim = 0;
      m_reached = 0; m_irq = 0; m_mode = 2'd0; m_rexp = 0;
    end else begin
      tk   = m_run && (m_pre == DIV - 1);
      hit  = (m_cnt == m_lim);
      usr  = (m_mode == 2'd1);
      wr0  = wr_en && addr == 3'd0;
      wr2  = wr_en && addr == 3'd2;
      wrm  = wr_en && addr == 3'd3 && m_mode != 2'd2;
      rd0  = rd_en && addr == 3'd0 && !usr;
      evt  = tk && hit && !wr0;
      entu = wrm && wdata[0];
      if (rd_en) begin
        case (addr)
          3'd0, 3'd2: m_rexp = {1'b0, m_lim, 9'b0};
          3'd1:       m_rexp = {m_reached, m_cnt, 9'b0};
          3'd3:       m_rexp = {30'b0, m_mode};
          default:    m_rexp = 0;
        endcase
      end
      if (wr0 || entu) m_irq = 0;
      else if (evt && !usr) m_irq = 1;
      else if (rd0) m_irq = 0;
      if (evt) m_reached = 1; else if (rd0) m_reached = 0;
      if (wr0) m_cnt = 0; else if (tk) m_cnt = hit ? 22'd0 : m_cnt + 22'd1;
      if (wr0 || !m_run || tk) m_pre = 0; else m_pre = m_pre + 1;
      if (entu) m_lim = FULL;
      else if ((wr0 || wr2) && !usr) m_lim = wdata[30:9];
      if (wr0 || wr2 || entu) m_run = 1;
      if (wrm) m_mode = wdata[0] ? 2'd1 : 2'd0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R3 / R8: interrupt level compared against the model every cycle
  always @(negedge clk) if (irq_watch && !done) check("R3 irq level", {31'b0, irq}, {31'b0, m_irq});

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    check(tag, rdata, m_rexp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] limw(input logic [21:0] l);
    return {1'b0, l, 9'b0};
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    idle(3);
    rst = 0;
    idle(1);
    check("R1 irq after reset", {31'b0, irq}, 32'd0);
    rd(3'd1, "R1 count after reset");
    check("R1 count zero", rdata, 32'd0);
    rd(3'd3, "R1 mode after reset");
    idle(25);
    rd(3'd1, "R1 stays stopped");
    check("R1 stopped count", rdata, 32'd0);
    irq_watch = 1;

    // directed: restart with limit 3, watch event and ack
    wr(3'd0, limw(22'd3));
    rd(3'd1, "R5 count after restart");
    idle(9);
    rd(3'd1, "R2 count advancing");
    idle(10);
    rd(3'd1, "R3 reached bit");
    rd(3'd0, "R4 limit read ack");
    idle(1);
    rd(3'd2, "R6 limit read no ack");
    wr(3'd2, limw(22'd9));
    rd(3'd1, "R6 count kept");
    // limit 0: event every tick
    wr(3'd0, limw(22'd0));
    idle(12);
    rd(3'd1, "R3 limit zero");
    // unused words
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, "R9 unused word");
    check("R9 unused zero", rdata, 32'd0);
    rd(3'd2, "R9 limit untouched");

    // user mode
    wr(3'd3, 32'd1);
    rd(3'd3, "R7 mode user");
    check("R7 user code", rdata, 32'd1);
    rd(3'd0, "R8 full limit");
    check("R8 limit all ones", rdata, 32'h7FFF_FE00);
    wr(3'd0, limw(22'd5));
    idle(40);
    rd(3'd2, "R8 limit held");
    rd(3'd1, "R8 free count");
    check("R8 no irq", {31'b0, irq}, 32'd0);
    wr(3'd3, 32'd0);
    rd(3'd3, "R7 mode processor");

    // system-mode instance
    @(negedge clk); s_wr = 1; s_addr = 3'd3; s_wdata = 32'd1;
    @(negedge clk); s_wr = 0; s_rd = 1;
    @(negedge clk); s_rd = 0;
    check("R7 system mode locked", s_rdata, 32'd2);
    @(negedge clk); s_wr = 1; s_addr = 3'd0; s_wdata = limw(22'd2);
    @(negedge clk); s_wr = 0;
    idle(13);
    check("R3 system irq raised", {31'b0, s_irq}, 32'd1);
    @(negedge clk); s_rd = 1;
    @(negedge clk); s_rd = 0;
    check("R4 system ack value", s_rdata, limw(22'd2));
    check("R4 system irq cleared", {31'b0, s_irq}, 32'd0);

    // random mix
    wr(3'd0, limw(22'd6));
    for (int it = 0; it < 500; it++) begin
      case ($urandom % 8)
        0, 1: idle($urandom % 30);
        2:    rd(3'd1, "R2 random count");
        3:    rd(3'd0, "R4 random ack");
        4:    wr(3'd0, limw(22'($urandom % 21)));
        5: begin
          if (m_mode == 2'd1 || m_lim > FULL - 22'd5) wr(3'd2, limw(m_lim));
          else wr(3'd2, limw(m_lim + 22'($urandom % 5)));
        end
        6:    if ($urandom % 4 == 0) wr(3'd3, {31'b0, 1'($urandom % 2)});
                else rd(3'd2, "R6 random limit");
        default: rd(3'($urandom % 8), "R9 random word");
      endcase
    end
    rd(3'd3, "R7 final mode");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule